// File: doc/BRIEF.md
# Two-Level Interrupt Gate for Two CPUs

This block sits between a set of device interrupt lines and two processor cores. A source reaches a core only when it passes two gates in series. The first is a single global enable per source, shared by both cores. The second is a per-core unmask bit for that source. Each core gets one level-sensitive request line. The line is the registered OR of every source that is pending, globally enabled and unmasked for that core.

Software drives the block over a simple single-cycle register bus. The bus carries a sideband that names the issuing core. Global enables are changed by writing a source index to a set register or to a clear register. Per-core masks are changed through a banked set/clear pair, which acts on the masks of whichever core issued the access. A second path for the masks is one control word per source, which rewrites that source's unmask bit for every core in a single write. This path is used to assign affinity. A software-trigger register can latch any source as pending, and that latched source passes through both gates like a device line. Reads return data one cycle after the request.

Byte addresses: 0x000 identity (read-only), 0x004 software trigger, 0x008 global set, 0x00C global clear, 0x010 banked unmask-set, 0x014 banked unmask-clear, 0x100 + 4*s per-source affinity word for source s.

Top module: `irq_twolevel_gate`

## Requirements
- R1: After reset all global enables are off, every per-core mask bit is masked (0), no source is latched by software, and `cpu_irq` is 0.
- R2: A write of index n (n < NSRC, taken from `bus_wdata[30:0]`) to 0x008 turns on the global enable of source n. Reading 0x008 or 0x00C returns the global enable vector, with bit n for source n.
- R3: A write of index n to 0x00C turns off the global enable of source n and leaves the other enables unchanged.
- R4: A write of index n to 0x010 sets bit n of the unmask vector of the core named by `bus_cpu`. A write to 0x014 clears that bit. Neither write changes the other core's masks.
- R5: A write to 0x008, 0x00C, 0x010, 0x014 or 0x004 whose index field is NSRC or more changes no state.
- R6: A write to 0x100 + 4*s sets core c's unmask bit for source s to `bus_wdata[c]`, for every core at once. A read of that address returns those bits in `bus_rdata[NCPU-1:0]`.
- R7: `cpu_irq[c]` equals, one clock after the state is present, the OR over sources of (pending AND global enable AND core c unmask). Clearing either the enable or the unmask bit blocks the source.
- R8: A write to 0x004 with bit 31 clear and index n latches source n as pending. A write with bit 31 set and index n releases that latch. A source is pending when its `src_irq` line is high or it is latched. Reading 0x004 returns the pending vector.
- R9: A read of 0x010 or 0x014 returns the gated vector (pending AND global enable AND unmask) of the core named by `bus_cpu`.
- R10: A read of 0x000 returns NSRC in bits 7:0 and NCPU in bits 15:8. Every read raises `bus_rvalid` with its data in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_irq | input | NSRC | Level interrupt lines from devices |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Index of the core issuing the access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High for one cycle after each read |
| cpu_irq | output | NCPU | Level interrupt request per core |

## Verification
The assertions assume that the bus carries at most one access per cycle and that `bus_cpu` is stable while `bus_valid` is high. They also assume NSRC is at most 32, so that every index and vector fits the 32-bit data word. The bench issues each access as a single strobe that is held from one falling edge to the next, and always names a core that exists. It also deliberately drives indices of 32 and above, which go past the last source. The bench changes the device lines only between accesses, so each state change has a single cause that the reference model can follow.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

  // Register byte offsets
  localparam int unsigned OFS_IDENT  = 32'h000;
  localparam int unsigned OFS_SWTRIG = 32'h004;
  localparam int unsigned OFS_GSET   = 32'h008;
  localparam int unsigned OFS_GCLR   = 32'h00C;
  localparam int unsigned OFS_MSET   = 32'h010;
  localparam int unsigned OFS_MCLR   = 32'h014;
  localparam int unsigned AFF_PAGE   = 32'h1;   // address bits above 7 select the affinity page

  typedef struct packed {
    logic gset;
    logic gclr;
    logic swset;
    logic swclr;
    logic mset;
    logic mclr;
    logic aff;
  } irqg_cmd_t;

endpackage

// File: rtl/irqg_regif.sv
module irqg_regif
  import irqg_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NCPU   = 2,
  parameter int ADDR_W = 12,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [CPU_W-1:0]          bus_cpu,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  input  logic [NSRC-1:0]           gen_q,
  input  logic [NSRC-1:0]           pend,
  input  logic [NCPU-1:0][NSRC-1:0] mask_q,
  input  logic [NCPU-1:0][NSRC-1:0] gated,
  output irqg_cmd_t                 cmd,
  output logic [IDX_W-1:0]          cmd_idx,
  output logic [NCPU-1:0]           cmd_cpu_oh,
  output logic [NCPU-1:0]           cmd_aff_bits,
  output logic [31:0]               rdata,
  output logic                      rvalid
);

  logic        wr_req, rd_req;
  logic [30:0] num;
  logic        num_ok, cpu_ok, aff_win, slot_ok;
  logic [5:0]  slot;
  logic [31:0] rdata_d;

  assign wr_req  = bus_valid & bus_write;
  assign rd_req  = bus_valid & ~bus_write;
  assign num     = bus_wdata[30:0];
  assign num_ok  = (num < 31'(NSRC));
  assign cpu_ok  = (32'(bus_cpu) < NCPU);
  assign aff_win = (bus_addr[ADDR_W-1:8] == (ADDR_W-8)'(AFF_PAGE));
  assign slot    = bus_addr[7:2];
  assign slot_ok = (slot < 6'(NSRC));

  // Write decode
  always_comb begin
    cmd       = '0;
    cmd.gset  = wr_req & (bus_addr == ADDR_W'(OFS_GSET)) & num_ok;
    cmd.gclr  = wr_req & (bus_addr == ADDR_W'(OFS_GCLR)) & num_ok;
    cmd.swset = wr_req & (bus_addr == ADDR_W'(OFS_SWTRIG)) & ~bus_wdata[31] & num_ok;
    cmd.swclr = wr_req & (bus_addr == ADDR_W'(OFS_SWTRIG)) &  bus_wdata[31] & num_ok;
    cmd.mset  = wr_req & (bus_addr == ADDR_W'(OFS_MSET)) & num_ok & cpu_ok;
    cmd.mclr  = wr_req & (bus_addr == ADDR_W'(OFS_MCLR)) & num_ok & cpu_ok;
    cmd.aff   = wr_req & aff_win & slot_ok;
    cmd_idx   = aff_win ? slot[IDX_W-1:0] : num[IDX_W-1:0];
    cmd_aff_bits = bus_wdata[NCPU-1:0];
    for (int c = 0; c < NCPU; c++) begin
      cmd_cpu_oh[c] = (32'(bus_cpu) == c);
    end
  end

  // Read mux (next state)
  always_comb begin
    rdata_d = '0;
    if (aff_win) begin
      if (slot_ok) begin
        for (int c = 0; c < NCPU; c++) begin
          rdata_d[c] = mask_q[c][slot[IDX_W-1:0]];
        end
      end
    end else begin
      case (32'(bus_addr))
        OFS_IDENT:            rdata_d = {16'h0, 8'(NCPU), 8'(NSRC)};
        OFS_SWTRIG:           rdata_d = 32'(pend);
        OFS_GSET, OFS_GCLR:   rdata_d = 32'(gen_q);
        OFS_MSET, OFS_MCLR:   rdata_d = cpu_ok ? 32'(gated[bus_cpu]) : 32'h0;
        default:              rdata_d = 32'h0;
      endcase
    end
  end

  // Read registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= rdata_d;
    end
  end

  assert_rvalid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rvalid);
  assert_no_spurious_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rvalid);

endmodule

// File: rtl/irqg_global.sv
module irqg_global #(
  parameter int NSRC = 32,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gset,
  input  logic             gclr,
  input  logic             swset,
  input  logic             swclr,
  input  logic [IDX_W-1:0] idx,
  input  logic [NSRC-1:0]  src_irq,
  output logic [NSRC-1:0]  gen_q,
  output logic [NSRC-1:0]  pend,
  output logic [NSRC-1:0]  stage
);

  logic [NSRC-1:0] gen_d, sw_q, sw_d;
  logic            gen_en, sw_en;

  assign gen_en = gset | gclr;
  assign sw_en  = swset | swclr;

  always_comb begin
    gen_d = gen_q;
    if (gset) gen_d[idx] = 1'b1;
    if (gclr) gen_d[idx] = 1'b0;
    sw_d = sw_q;
    if (swset) sw_d[idx] = 1'b1;
    if (swclr) sw_d[idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= '0;
      sw_q  <= '0;
    end else begin
      if (gen_en) gen_q <= gen_d;
      if (sw_en)  sw_q  <= sw_d;
    end
  end

  assign pend  = src_irq | sw_q;
  assign stage = pend & gen_q;

  assert_gset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gset |=> gen_q[$past(idx)]);
  assert_gclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gclr |=> !gen_q[$past(idx)]);
  assert_swset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swset |=> pend[$past(idx)]);
  assert_gen_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(gset || gclr) |=> $stable(gen_q));

endmodule

// File: rtl/irqg_cpu_slice.sv
module irqg_cpu_slice #(
  parameter int NSRC   = 32,
  parameter int CPU_ID = 0,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic             aff_we,
  input  logic             aff_bit,
  input  logic [IDX_W-1:0] idx,
  input  logic [NSRC-1:0]  stage,
  output logic [NSRC-1:0]  mask_q,
  output logic [NSRC-1:0]  gated,
  output logic             irq_q
);

  logic [NSRC-1:0] mask_d;
  logic            mask_en;
  logic            irq_d;

  assign mask_en = set_we | clr_we | aff_we;

  always_comb begin
    mask_d = mask_q;
    if (set_we) mask_d[idx] = 1'b1;
    if (clr_we) mask_d[idx] = 1'b0;
    if (aff_we) mask_d[idx] = aff_bit;
  end

  assign gated = stage & mask_q;
  assign irq_d = |gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      irq_q <= irq_d;
    end
  end

  assert_mset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> mask_q[$past(idx)]);
  assert_mclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> !mask_q[$past(idx)]);
  assert_aff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    aff_we |=> (mask_q[$past(idx)] == $past(aff_bit)));

endmodule

// File: rtl/irq_twolevel_gate.sv
module irq_twolevel_gate
  import irqg_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NCPU   = 2,
  parameter int ADDR_W = 12,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_irq,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [NCPU-1:0]   cpu_irq
);

  logic [1:0]                rst_pipe;
  logic                      rst_s;
  irqg_cmd_t                 cmd;
  logic [IDX_W-1:0]          cmd_idx;
  logic [NCPU-1:0]           cmd_cpu_oh, cmd_aff_bits;
  logic [NSRC-1:0]           gen_q, pend, stage;
  logic [NCPU-1:0][NSRC-1:0] mask_q, gated;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  irqg_regif #(.NSRC(NSRC), .NCPU(NCPU), .ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst_n(rst_s),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_cpu(bus_cpu),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .gen_q(gen_q), .pend(pend), .mask_q(mask_q), .gated(gated),
    .cmd(cmd), .cmd_idx(cmd_idx), .cmd_cpu_oh(cmd_cpu_oh), .cmd_aff_bits(cmd_aff_bits),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  irqg_global #(.NSRC(NSRC)) u_global (
    .clk(clk), .rst_n(rst_s),
    .gset(cmd.gset), .gclr(cmd.gclr), .swset(cmd.swset), .swclr(cmd.swclr),
    .idx(cmd_idx), .src_irq(src_irq),
    .gen_q(gen_q), .pend(pend), .stage(stage)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    irqg_cpu_slice #(.NSRC(NSRC), .CPU_ID(c)) u_slice (
      .clk(clk), .rst_n(rst_s),
      .set_we(cmd.mset & cmd_cpu_oh[c]),
      .clr_we(cmd.mclr & cmd_cpu_oh[c]),
      .aff_we(cmd.aff),
      .aff_bit(cmd_aff_bits[c]),
      .idx(cmd_idx), .stage(stage),
      .mask_q(mask_q[c]), .gated(gated[c]), .irq_q(cpu_irq[c])
    );

    assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_s)
      ($past(mask_q[c]) == '0) |-> !cpu_irq[c]);
  end

  // Global gate blocks every core
  assert_global_blocks_R7: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(gen_q) == '0) |-> (cpu_irq == '0));

  // Index past the last source leaves the enables alone
  logic wr_oob_g;
  assign wr_oob_g = bus_valid & bus_write & (bus_wdata[30:0] >= 31'(NSRC)) &
                    ((bus_addr == ADDR_W'(OFS_GSET)) || (bus_addr == ADDR_W'(OFS_GCLR)));
  assert_oob_ignored_R5: assert property (@(posedge clk) disable iff (!rst_s)
    wr_oob_g |=> $stable(gen_q));

  // State at reset release
  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_s) |-> (cpu_irq == '0 && gen_q == '0 && mask_q == '0));

endmodule

// File: tb/tb_irq_twolevel_gate.sv
module tb_irq_twolevel_gate;

  localparam int NSRC = 32;
  localparam int NCPU = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_irq;
  logic        bus_valid, bus_write;
  logic [0:0]  bus_cpu;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  cpu_irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // Reference model
  logic [31:0] m_gen, m_sw;
  logic [31:0] m_mask [2];

  // Scoreboard of expected read data
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  irq_twolevel_gate #(.NSRC(NSRC), .NCPU(NCPU), .ADDR_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_cpu(bus_cpu),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cpu_irq(cpu_irq)
  );

  function automatic logic [31:0] m_gated(int c);
    return (src_irq | m_sw) & m_gen & m_mask[c];
  endfunction

  function automatic logic [1:0] m_irq();
    logic [1:0] r;
    for (int c = 0; c < 2; c++) r[c] = |m_gated(c);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pop and compare read results
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) check("R10 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [0:0] cpu);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = cpu;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [0:0] cpu, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_cpu = cpu;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk_irq(string tag);
    @(negedge clk);
    check(tag, 32'(cpu_irq), 32'(m_irq()));
  endtask

  task automatic gset(int n, string tag);
    wr(12'h008, 32'(n), 1'b0);
    if (n < NSRC) m_gen[n] = 1'b1;
    chk_irq(tag);
  endtask

  task automatic gclr(int n, string tag);
    wr(12'h00C, 32'(n), 1'b0);
    if (n < NSRC) m_gen[n] = 1'b0;
    chk_irq(tag);
  endtask

  task automatic mset(int cpu, int n, string tag);
    wr(12'h010, 32'(n), 1'(cpu));
    if (n < NSRC) m_mask[cpu][n] = 1'b1;
    chk_irq(tag);
  endtask

  task automatic mclr(int cpu, int n, string tag);
    wr(12'h014, 32'(n), 1'(cpu));
    if (n < NSRC) m_mask[cpu][n] = 1'b0;
    chk_irq(tag);
  endtask

  task automatic aff(int s, logic [1:0] bits, string tag);
    wr(12'h100 + 12'(4 * s), 32'(bits), 1'b0);
    for (int c = 0; c < 2; c++) m_mask[c][s] = bits[c];
    chk_irq(tag);
  endtask

  task automatic swtrig(int n, bit release_it, string tag);
    wr(12'h004, {release_it, 31'(n)}, 1'b0);
    if (n < NSRC) m_sw[n] = !release_it;
    chk_irq(tag);
  endtask

  task automatic line(int n, logic v, string tag);
    @(negedge clk);
    src_irq[n] = v;
    chk_irq(tag);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_irq = '0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_cpu = '0; bus_addr = '0; bus_wdata = '0;
    m_gen = '0; m_sw = '0; m_mask[0] = '0; m_mask[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, R10 identity
    check("R1 cpu_irq after reset", 32'(cpu_irq), 32'h0);
    rd(12'h008, 1'b0, 32'h0, "R1 global enables after reset");
    rd(12'h004, 1'b0, 32'h0, "R1 pending after reset");
    rd(12'h100 + 12'd20, 1'b0, 32'h0, "R1 masks of source 5 after reset");
    rd(12'h000, 1'b0, 32'h0000_0220, "R10 identity word");

    // R7 device line through both levels
    line(3, 1'b1, "R7 line alone blocked");
    gset(3, "R2 enable 3 still masked R7");
    rd(12'h008, 1'b0, 32'h0000_0008, "R2 enable vector");
    mset(0, 3, "R4 unmask 3 for core 0 R7");
    rd(12'h010, 1'b0, 32'h0000_0008, "R9 banked gated core 0");
    rd(12'h010, 1'b1, 32'h0000_0000, "R9 banked gated core 1");
    aff(3, 2'b10, "R6 move 3 to core 1");
    rd(12'h10C, 1'b0, 32'h0000_0002, "R6 affinity readback");
    aff(3, 2'b11, "R6 both cores");
    mclr(1, 3, "R4 clear core 1 only");
    rd(12'h10C, 1'b0, 32'h0000_0001, "R4 banked clear left core 0");
    gclr(3, "R3 global clear blocks core 0 R7");
    gset(3, "R2 re-enable");
    line(3, 1'b0, "R7 line drop");

    // R5 out-of-range indices
    gset(40, "R5 set index 40");
    rd(12'h008, 1'b0, m_gen, "R5 enables unchanged after index 40");
    gclr(35, "R5 clear index 35");
    rd(12'h008, 1'b0, m_gen, "R5 enables unchanged after index 35");
    mset(0, 33, "R5 unmask index 33");
    rd(12'h104, 1'b0, 32'h0000_0000, "R5 source 1 masks untouched");
    swtrig(32, 1'b0, "R5 trigger index 32");
    rd(12'h004, 1'b0, 32'h0000_0000, "R5 no latch from index 32");

    // R8 software trigger
    swtrig(7, 1'b0, "R8 latch 7 no enable");
    rd(12'h004, 1'b0, 32'h0000_0080, "R8 pending readback");
    gset(7, "R8 enable 7 still masked");
    mset(1, 7, "R8 unmask 7 core 1");
    rd(12'h014, 1'b1, 32'h0000_0080, "R9 banked gated core 1 source 7");
    rd(12'h014, 1'b0, 32'h0000_0000, "R9 banked gated core 0 source 7");
    swtrig(7, 1'b1, "R8 release 7");
    rd(12'h004, 1'b0, 32'h0000_0000, "R8 pending after release");

    // Boundary sources 0 and 31
    line(31, 1'b1, "R7 line 31 blocked");
    gset(31, "R2 enable 31");
    aff(31, 2'b01, "R6 source 31 to core 0");
    line(0, 1'b1, "R7 line 0 blocked");
    gset(0, "R2 enable 0");
    mset(1, 0, "R4 unmask 0 core 1");
    mclr(0, 31, "R4 mask 31 core 0");
    gclr(0, "R3 clear 0 keeps others");
    rd(12'h008, 1'b0, m_gen, "R3 enable vector after clears");
    line(31, 1'b0, "R7 line 31 drop");
    line(0, 1'b0, "R7 line 0 drop");

    repeat (4) @(negedge clk);
    check("R10 scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule